// File: doc/BRIEF.md
# Counter Peripheral SPI Register Port

This block is the serial front end of a quadrature counter peripheral. A host acting as SPI master (mode 0, 8-bit framing) lowers an active-low chip select and sends an instruction byte. That byte selects an operation (clear, read or write) and one of six counter-core registers. The block then moves the data bytes, most significant byte first. When the frame is complete, it issues one-cycle strobes toward the counter core: write enables with the assembled write value, clear strobes, and a snapshot strobe that copies the live count into the output-holding register.

The transfer length depends on which register is addressed. The two mode registers and the status register always move one byte. The preset, count and output-holding registers move the configured counter width of 1 to 4 bytes, which is read from a two-bit field in mode register 1. A read of the count never returns the running counter directly. The block first pulses the snapshot strobe and then shifts out the output-holding register. The serial pins are oversampled and synchronised into the system clock domain, and the system clock must run at least eight times faster than SCK.

Top module: `cspi_regport`

## Requirements
- R1: Instruction byte, sent MSB first on MOSI and sampled on rising SCK: bits 7:6 are the operation (00 clear, 01 read, 10 write, 11 ignored). Bits 5:3 are the register select (001 mode0, 010 mode1, 011 preset, 100 count, 101 output-holding, 110 status). Bits 2:0 are ignored.
- R2: A clear instruction pulses `clr_o[sel-1]` for one clock after its eighth bit and moves no data.
- R3: A read or write of mode0, mode1 or status moves exactly one data byte, whatever the configured width.
- R4: A read or write of preset, count or output-holding moves N = 4 - `mode1_i[1:0]` bytes. A field value of 0 means 4 bytes and 3 means 1 byte.
- R5: Read data leaves MSB first. MISO changes only after falling SCK edges, and the first data bit is valid before the first rising edge of the byte that follows the instruction.
- R6: A count read pulses `snap_o` exactly once and returns the output-holding value captured by that snapshot. A read of the output-holding register pulses no snapshot and returns the last captured value.
- R7: A write pulses `wr_en_o[sel-1]` for one clock after the last data bit, with `wr_data_o` holding the received value right-aligned and zero above the transferred bytes.
- R8: If chip select rises before the last data bit of a write, no write enable is issued, and the next frame starts again with an instruction byte.
- R9: Bytes clocked after the transfer length are ignored: they cause no further strobes before chip select rises.
- R10: Operation 11 and register selects 000 and 111 produce no strobe, and MISO stays low for the rest of the frame.
- R11: MISO is low while deselected, during the instruction byte and during write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n_i | input | 1 | Active-low chip select, frames a transaction |
| spi_mosi_i | input | 1 | Serial data from master |
| spi_miso_o | output | 1 | Serial data to master |
| mode0_i | input | 8 | Current mode register 0 value |
| mode1_i | input | 8 | Current mode register 1 value; bits 1:0 hold the width code |
| preset_i | input | 32 | Current preset register value |
| out_i | input | 32 | Current output-holding register value |
| status_i | input | 8 | Current status register value |
| wr_en_o | output | 6 | One-hot write enable, bit = select code minus one |
| wr_data_o | output | 32 | Right-aligned write value, valid with `wr_en_o` |
| clr_o | output | 6 | One-hot clear strobe, bit = select code minus one |
| snap_o | output | 1 | Copy count into output-holding register |

## Verification
A wrong bit or phase counter in this block shows at the ports within the same frame. It appears as a write enable issued one byte early or late, or as a strobe for the wrong register. The bench model flags such a strobe on the clock it appears, because every strobe must match the front of its queue of expected events. A misaligned transmit shifter or a missing snapshot wait corrupts the very next byte read back on MISO. A stale value after an aborted frame shows on the next read of the same register.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

    localparam int CNT_BYTES_MAX = 4;
    localparam int CNT_W         = 8 * CNT_BYTES_MAX;
    localparam int WFIELD_W      = $clog2(CNT_BYTES_MAX);
    localparam int BITCNT_W      = $clog2(CNT_W + 1);
    localparam int NUM_REGS      = 6;
    localparam int SEL_W         = 3;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        RS_NONE   = 3'd0,
        RS_MODE0  = 3'd1,
        RS_MODE1  = 3'd2,
        RS_PRESET = 3'd3,
        RS_COUNT  = 3'd4,
        RS_OUTPUT = 3'd5,
        RS_STATUS = 3'd6,
        RS_RSVD   = 3'd7
    } rsel_e;

    typedef enum logic [2:0] {
        PH_INSTR,
        PH_SNAP,
        PH_LOAD,
        PH_READ,
        PH_WRITE,
        PH_DONE
    } phase_e;

    typedef struct packed {
        op_e   op;
        rsel_e sel;
        logic  sel_ok;
        logic  wide;
    } instr_t;

    function automatic logic [NUM_REGS-1:0] sel_onehot(rsel_e s);
        logic [NUM_REGS-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            r[i] = (s == rsel_e'(SEL_W'(i + 1)));
        end
        return r;
    endfunction

endpackage

// File: rtl/cspi_pin_sync.sv
module cspi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_act_o,
    output logic mosi_o
);

    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] dat;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d     = q;
        d.sck = {q.sck[STAGES-1:0], sclk_i};
        d.csn = {q.csn[STAGES-2:0], cs_n_i};
        d.dat = {q.dat[STAGES-2:0], mosi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck <= '0;
            q.csn <= '1;
            q.dat <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise_o = q.sck[STAGES-1] & ~q.sck[STAGES];
    assign sclk_fall_o = ~q.sck[STAGES-1] & q.sck[STAGES];
    assign cs_act_o    = ~q.csn[STAGES-1];
    assign mosi_o      = q.dat[STAGES-1];

endmodule

// File: rtl/cspi_instr_decode.sv
module cspi_instr_decode
    import cspi_pkg::*;
(
    input  logic [7:0] byte_i,
    output instr_t     dec_o
);

    logic unused_low;
    assign unused_low = ^byte_i[2:0];

    always_comb begin
        dec_o.op     = op_e'(byte_i[7:6]);
        dec_o.sel    = rsel_e'(byte_i[5:3]);
        dec_o.sel_ok = (int'(byte_i[5:3]) >= 1) && (int'(byte_i[5:3]) <= NUM_REGS);
        dec_o.wide   = (dec_o.sel == RS_PRESET) || (dec_o.sel == RS_COUNT) ||
                       (dec_o.sel == RS_OUTPUT);
    end

endmodule

// File: rtl/cspi_regport.sv
module cspi_regport
    import cspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sclk_i,
    input  logic                spi_cs_n_i,
    input  logic                spi_mosi_i,
    output logic                spi_miso_o,
    input  logic [7:0]          mode0_i,
    input  logic [7:0]          mode1_i,
    input  logic [CNT_W-1:0]    preset_i,
    input  logic [CNT_W-1:0]    out_i,
    input  logic [7:0]          status_i,
    output logic [NUM_REGS-1:0] wr_en_o,
    output logic [CNT_W-1:0]    wr_data_o,
    output logic [NUM_REGS-1:0] clr_o,
    output logic                snap_o
);

    typedef struct packed {
        phase_e              ph;
        logic [BITCNT_W-1:0] bits;
        logic [BITCNT_W-1:0] nbits;
        logic [6:0]          instr;
        rsel_e               tgt;
        logic [CNT_W-1:0]    rx;
        logic [CNT_W-1:0]    tx;
        logic                pend;
        logic [NUM_REGS-1:0] wr_en;
        logic [NUM_REGS-1:0] clr;
        logic                snap;
    } ctl_t;

    logic sclk_rise, sclk_fall, cs_act, mosi_s;
    instr_t dec;
    ctl_t d, q;
    logic [BITCNT_W-1:0] nbytes_cfg;
    logic [BITCNT_W-1:0] load_shift;
    logic [CNT_W-1:0]    rd_val;
    logic [BITCNT_W-1:0] bits_inc;

    cspi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (spi_sclk_i),
        .cs_n_i     (spi_cs_n_i),
        .mosi_i     (spi_mosi_i),
        .sclk_rise_o(sclk_rise),
        .sclk_fall_o(sclk_fall),
        .cs_act_o   (cs_act),
        .mosi_o     (mosi_s)
    );

    cspi_instr_decode dec_i (
        .byte_i({q.instr, mosi_s}),
        .dec_o (dec)
    );

    // width code holds (max bytes - configured bytes)
    assign nbytes_cfg = BITCNT_W'(CNT_BYTES_MAX) - BITCNT_W'(mode1_i[WFIELD_W-1:0]);
    assign load_shift = BITCNT_W'(CNT_W) - q.nbits;
    assign bits_inc   = q.bits + BITCNT_W'(1);

    always_comb begin
        case (q.tgt)
            RS_MODE0:  rd_val = CNT_W'(mode0_i);
            RS_MODE1:  rd_val = CNT_W'(mode1_i);
            RS_PRESET: rd_val = preset_i;
            RS_STATUS: rd_val = CNT_W'(status_i);
            default:   rd_val = out_i;
        endcase
    end

    always_comb begin
        d       = q;
        d.wr_en = '0;
        d.clr   = '0;
        d.snap  = 1'b0;
        if (!cs_act) begin
            d.ph   = PH_INSTR;
            d.bits = '0;
            d.pend = 1'b0;
            d.tx   = '0;
        end else begin
            case (q.ph)
                PH_INSTR: begin
                    if (sclk_rise) begin
                        d.instr = {q.instr[5:0], mosi_s};
                        d.bits  = bits_inc;
                        if (q.bits == BITCNT_W'(7)) begin
                            d.bits  = '0;
                            d.tgt   = dec.sel;
                            d.nbits = dec.wide ? BITCNT_W'(nbytes_cfg << 3) : BITCNT_W'(8);
                            d.rx    = '0;
                            if (!dec.sel_ok) begin
                                d.ph = PH_DONE;
                            end else begin
                                case (dec.op)
                                    OP_CLEAR: begin
                                        d.clr = sel_onehot(dec.sel);
                                        d.ph  = PH_DONE;
                                    end
                                    OP_READ: begin
                                        d.snap = (dec.sel == RS_COUNT);
                                        d.ph   = PH_SNAP;
                                    end
                                    OP_WRITE: d.ph = PH_WRITE;
                                    default:  d.ph = PH_DONE;
                                endcase
                            end
                        end
                    end
                end
                // one idle cycle lets the core register the snapshot
                PH_SNAP: d.ph = PH_LOAD;
                PH_LOAD: begin
                    d.tx = rd_val << load_shift;
                    d.ph = PH_READ;
                end
                PH_READ: begin
                    if (sclk_rise) begin
                        d.pend = 1'b1;
                        d.bits = bits_inc;
                        if (bits_inc == q.nbits) d.ph = PH_DONE;
                    end else if (sclk_fall && q.pend) begin
                        d.tx   = q.tx << 1;
                        d.pend = 1'b0;
                    end
                end
                PH_WRITE: begin
                    if (sclk_rise) begin
                        d.rx   = {q.rx[CNT_W-2:0], mosi_s};
                        d.bits = bits_inc;
                        if (bits_inc == q.nbits) begin
                            d.wr_en = sel_onehot(q.tgt);
                            d.ph    = PH_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso_o = q.tx[CNT_W-1];
    assign wr_en_o    = q.wr_en;
    assign wr_data_o  = q.rx;
    assign clr_o      = q.clr;
    assign snap_o     = q.snap;

    p_wr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o));

    p_clr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    p_snap_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snap_o |-> (wr_en_o == '0 && clr_o == '0));

    p_no_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (wr_en_o == '0));

    p_miso_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_READ && cs_act && !sclk_fall) |=> $stable(spi_miso_o));

endmodule

// File: tb/cspi_regport_tb_top.sv
module cspi_regport_tb_top;

    localparam int HALF = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sclk, cs_n, mosi, miso;
    logic [7:0]  m_mode0, m_mode1, m_status;
    logic [31:0] m_preset, m_count, m_out;
    logic [5:0]  wr_en, clr;
    logic [31:0] wr_data;
    logic        snap;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int          exp_kind[$];
    int          exp_idx[$];
    logic [31:0] exp_data[$];
    logic [7:0]  tx_bytes[$];
    logic [7:0]  rx_bytes[$];

    cspi_regport dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
        .mode0_i(m_mode0), .mode1_i(m_mode1), .preset_i(m_preset), .out_i(m_out),
        .status_i(m_status), .wr_en_o(wr_en), .wr_data_o(wr_data), .clr_o(clr),
        .snap_o(snap)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic take_exp(input int kind, input logic [5:0] vec, input logic [31:0] dat,
                            input string tag);
        logic [5:0]  ev;
        logic [31:0] ed;
        bit ok;
        ok = (exp_kind.size() > 0);
        ev = 6'd0;
        ed = 32'd0;
        if (ok) begin
            ok = (exp_kind[0] == kind);
            ev = 6'b1 << exp_idx[0];
            ed = exp_data[0];
            void'(exp_kind.pop_front());
            void'(exp_idx.pop_front());
            void'(exp_data.pop_front());
        end
        chk(ok && vec == ev && dat == ed, tag, {vec, dat[25:0]}, {ev, ed[25:0]});
    endtask

    // behavioural counter core plus strobe monitor, compared every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            m_count = m_count + 1;
            if (wr_en != 6'd0) begin
                take_exp(0, wr_en, wr_data, "R7 write strobe/data");
                if (wr_en[0]) m_mode0  = wr_data[7:0];
                if (wr_en[1]) m_mode1  = wr_data[7:0];
                if (wr_en[2]) m_preset = wr_data;
                if (wr_en[3]) m_count  = wr_data;
                if (wr_en[4]) m_out    = wr_data;
                if (wr_en[5]) m_status = wr_data[7:0];
            end
            if (clr != 6'd0) begin
                take_exp(1, clr, 32'd0, "R2 clear strobe");
                if (clr[0]) m_mode0  = 8'd0;
                if (clr[1]) m_mode1  = 8'd0;
                if (clr[2]) m_preset = 32'd0;
                if (clr[3]) m_count  = 32'd0;
                if (clr[4]) m_out    = 32'd0;
                if (clr[5]) m_status = 8'd0;
            end
            if (snap) begin
                take_exp(2, 6'd1, 32'd0, "R6 snapshot strobe");
                m_out = m_count;
            end
        end
    end

    task automatic spi_xfer(input int nb);
        rx_bytes.delete();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            logic [7:0] r;
            r = 8'd0;
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_bytes[b][i];
                repeat (HALF) @(negedge clk);
                r[i] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
            rx_bytes.push_back(r);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    function automatic int xfer_len(input logic [2:0] sel);
        if (sel == 3'd3 || sel == 3'd4 || sel == 3'd5) return 4 - int'(m_mode1[1:0]);
        return 1;
    endfunction

    function automatic logic [31:0] len_mask(input int n);
        return (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 32'd1);
    endfunction

    // R1: write instruction 10 sss xxx, data MSB first
    task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
        int n;
        n = xfer_len(sel);
        tx_bytes.delete();
        tx_bytes.push_back({2'b10, sel, 3'b000});
        for (int b = n - 1; b >= 0; b--) tx_bytes.push_back(val[8*b +: 8]);
        exp_kind.push_back(0);
        exp_idx.push_back(int'(sel) - 1);
        exp_data.push_back(val & len_mask(n));
        spi_xfer(n + 1);
        chk(exp_kind.size() == 0, "R7 write commit issued", 32'(exp_kind.size()), 32'd0);
    endtask

    task automatic reg_read(input logic [7:0] instr, output logic [31:0] got);
        int n;
        n = xfer_len(instr[5:3]);
        tx_bytes.delete();
        tx_bytes.push_back(instr);
        for (int b = 0; b < n; b++) tx_bytes.push_back(8'h00);
        if (instr[5:3] == 3'd4) begin
            exp_kind.push_back(2);
            exp_idx.push_back(0);
            exp_data.push_back(32'd0);
        end
        spi_xfer(n + 1);
        chk(rx_bytes[0] == 8'h00, "R11 MISO low during instruction", 32'(rx_bytes[0]), 32'd0);
        chk(exp_kind.size() == 0, "R6 snapshot strobe issued", 32'(exp_kind.size()), 32'd0);
        got = 32'd0;
        for (int b = 1; b <= n; b++) got = {got[23:0], rx_bytes[b]};
    endtask

    task automatic reg_clear(input logic [2:0] sel);
        tx_bytes.delete();
        tx_bytes.push_back({2'b00, sel, 3'b000});
        exp_kind.push_back(1);
        exp_idx.push_back(int'(sel) - 1);
        exp_data.push_back(32'd0);
        spi_xfer(1);
        chk(exp_kind.size() == 0, "R2 clear strobe issued", 32'(exp_kind.size()), 32'd0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R8 got=hang expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] g, g1, g2, g3;
        bit all_zero;
        m_mode0 = 8'd0; m_mode1 = 8'd0; m_status = 8'h5A;
        m_preset = 32'd0; m_count = 32'd0; m_out = 32'd0;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(miso == 1'b0 && wr_en == 6'd0 && clr == 6'd0 && snap == 1'b0,
            "R11 reset idle outputs", {miso, wr_en, clr, snap}, 32'd0);

        // R3: one-byte registers
        reg_write(3'd1, 32'h0000_00A5);
        reg_read(8'b01_001_000, g);
        chk(g == 32'hA5, "R3 mode0 write/read one byte", g, 32'hA5);
        reg_read(8'b01_110_000, g);
        chk(g == 32'h5A, "R3 status read one byte at width 4", g, 32'h5A);
        reg_write(3'd6, 32'h0000_0033);
        reg_read(8'b01_110_000, g);
        chk(g == 32'h33, "R3 status write/read", g, 32'h33);

        // R4 R5: width variants, MSB first
        reg_write(3'd3, 32'h1234_5678);
        reg_read(8'b01_011_000, g);
        chk(g == 32'h1234_5678, "R4 R5 preset four bytes", g, 32'h1234_5678);
        reg_write(3'd2, 32'h0000_0001);
        reg_write(3'd3, 32'hFFAB_CDEF);
        reg_read(8'b01_011_000, g);
        chk(g == 32'h00AB_CDEF, "R4 preset three bytes", g, 32'h00AB_CDEF);
        reg_write(3'd2, 32'h0000_0003);
        reg_write(3'd3, 32'h0000_0077);
        reg_read(8'b01_011_000, g);
        chk(g == 32'h77, "R4 preset one byte", g, 32'h77);

        // R6: count snapshot and output-holding register
        reg_write(3'd2, 32'h0000_0002);
        reg_read(8'b01_100_000, g1);
        chk(g1 == (m_out & 32'hFFFF) && g1 != 0, "R6 count read returns snapshot", g1, m_out & 32'hFFFF);
        reg_read(8'b01_101_000, g2);
        chk(g2 == g1, "R6 output register holds last snapshot", g2, g1);
        reg_read(8'b01_100_000, g3);
        chk(g3 != g1 && g3 == (m_out & 32'hFFFF), "R6 new snapshot on count read", g3, m_out & 32'hFFFF);

        // R2: clears
        reg_clear(3'd4);
        reg_read(8'b01_100_000, g);
        chk(g < g3, "R2 count restarted after clear", g, g3);
        reg_clear(3'd3);
        reg_read(8'b01_011_000, g);
        chk(g == 32'd0, "R2 preset cleared", g, 32'd0);

        // R8: aborted two-byte write, only one byte sent
        tx_bytes.delete();
        tx_bytes.push_back(8'b10_011_000);
        tx_bytes.push_back(8'hDE);
        tx_bytes.push_back(8'hAD);
        spi_xfer(2);
        reg_read(8'b01_011_000, g);
        chk(g == 32'd0, "R8 aborted write leaves preset", g, 32'd0);

        // R9: extra bytes after a one-byte write
        tx_bytes.delete();
        tx_bytes.push_back(8'b10_001_000);
        tx_bytes.push_back(8'h3C);
        tx_bytes.push_back(8'hFF);
        tx_bytes.push_back(8'h11);
        exp_kind.push_back(0); exp_idx.push_back(0); exp_data.push_back(32'h3C);
        spi_xfer(4);
        chk(exp_kind.size() == 0, "R9 single commit", 32'(exp_kind.size()), 32'd0);
        reg_read(8'b01_001_000, g);
        chk(g == 32'h3C, "R9 extra bytes ignored", g, 32'h3C);

        // R10: unknown select, op 11, reserved clear
        tx_bytes.delete();
        tx_bytes.push_back(8'b01_000_000);
        tx_bytes.push_back(8'h00);
        tx_bytes.push_back(8'h00);
        spi_xfer(3);
        all_zero = (rx_bytes[0] == 0 && rx_bytes[1] == 0 && rx_bytes[2] == 0);
        chk(all_zero, "R10 unknown select MISO low", {rx_bytes[0], rx_bytes[1], rx_bytes[2]}, 32'd0);
        tx_bytes.delete();
        tx_bytes.push_back(8'b11_001_000);
        tx_bytes.push_back(8'h99);
        spi_xfer(2);
        chk(rx_bytes[1] == 8'h00, "R10 op 11 MISO low", 32'(rx_bytes[1]), 32'd0);
        tx_bytes.delete();
        tx_bytes.push_back(8'b00_111_000);
        spi_xfer(1);
        reg_read(8'b01_001_000, g);
        chk(g == 32'h3C, "R10 ignored frames change nothing", g, 32'h3C);

        // R1: low instruction bits ignored
        reg_read(8'b01_001_101, g);
        chk(g == 32'h3C, "R1 instruction bits 2:0 ignored", g, 32'h3C);

        chk(exp_kind.size() == 0, "R10 no pending strobes at end", 32'(exp_kind.size()), 32'd0);
        finish_run();
    end

endmodule